// File: doc/BRIEF.md
# Serial Configuration Register Bank (I2C Slave)

This block is a two-wire bus slave that sits behind a chip's I2C-compatible pins. It runs at standard and fast mode bus rates (up to 400 kHz) and works entirely in the system clock domain. The incoming SCL and SDA levels pass through a two-flop synchronizer and a glitch filter, which requires three agreeing samples, before any edge is detected. SDA is driven open-drain: the block only ever asks for the line to be pulled low.

The block holds twelve writable configuration bytes and two read-only status bytes, all reached through a single register pointer. A write sets the pointer and then stores a burst of data bytes. A read sets the pointer with a short write, issues a repeated START, and then streams bytes out until the master NACKs. The pointer advances by one after every data byte in either direction.

The writable bytes are exported on one flat bus. Writing one chosen register produces a one-cycle start pulse for a calibration engine. A power-on flag is set at reset and clears only after the first status byte has been read and the transaction has then closed with a STOP. One input pin selects between two bus addresses.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The block answers only to the 7-bit address 110000A, where A is `addr_sel`, so the write/read bytes are 0xC0/0xC1 or 0xC2/0xC3. Any other address byte is not acknowledged: SDA stays released through the ninth clock, and the rest of the transaction is ignored.
- R2: A write consists of the address byte with R/W=0, a pointer byte, and data bytes sent MSB first. Successive data bytes land in successive registers until STOP. Register k appears on `cfg_regs[8k+7:8k]` for k = 0..11.
- R3: A read consists of a pointer write, a repeated START, and then the address byte with R/W=1. The slave returns bytes MSB first starting at the pointer. A master ACK fetches the next register. A master NACK ends the read and releases SDA.
- R4: After reset the twelve writable bytes at 0x00..0x0B hold, in address order, 80 23 02 F6 84 01 C0 CC 4B 00 00 08 (hex). In the same state `sda_oe` is 0 and `cal_start` is 0.
- R5: `por_flag` is 1 after reset and reads back as bit 7 of address 0x0C, whose bits 6..0 are `stat_a_in`. Address 0x0D returns `stat_b_in`. The flag goes to 0 only when a byte has been returned from 0x0C and the transaction has then ended with STOP. It never returns to 1 until the next reset.
- R6: Every data byte written to address 0x04 produces exactly one single-cycle pulse on `cal_start`. Writes to any other address produce no pulse.
- R7: Data bytes written to 0x0C or 0x0D are acknowledged and discarded. The pointer steps from 0x0D back to 0x00. A pointer byte of 0x0E or above loads 0x00.
- R8: A pulse on SCL or SDA that lasts fewer than three system-clock samples has no effect on the transfer.
- R9: Every acknowledge the slave gives holds SDA low across the whole high phase of the ninth SCL pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired line) |
| addr_sel | input | 1 | Selects the low bit of the slave address |
| stat_a_in | input | 7 | Low seven bits of status byte 0x0C |
| stat_b_in | input | 8 | Status byte 0x0D |
| sda_oe | output | 1 | 1 = pull SDA low |
| cfg_regs | output | 96 | Writable registers 0x00..0x0B, byte k at bits 8k+7:8k |
| cal_start | output | 1 | One-cycle pulse per write to 0x04 |
| por_flag | output | 1 | Power-on flag |

## Verification
Random bursts start at any pointer from 0x00 to 0x0D and run for one to four bytes. Because the start points include the read-only addresses and the wrap point, these bursts separate a design that auto-increments correctly from one that stalls, skips, wraps late, or lets the status addresses swallow data. Directed transactions cover the remaining cases:
- address bytes that should and should not match under both `addr_sel` levels, which separates the address decoder from a slave that answers everything;
- reads that cross 0x0C, with and without a following STOP, which pin the exact moment the power-on flag may clear;
- short SCL and SDA pulses injected mid-byte, which show whether the filter, rather than luck, keeps the transfer intact.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int NUM_WR  = 12;
  localparam int NUM_ALL = 14;
  localparam int AW      = $clog2(NUM_ALL);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK} st_t;
  typedef enum logic [1:0] {PH_DEV, PH_PTR, PH_DATA} ph_t;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:  return 8'h80;
      1:  return 8'h23;
      2:  return 8'h02;
      3:  return 8'hF6;
      4:  return 8'h84;
      5:  return 8'h01;
      6:  return 8'hC0;
      7:  return 8'hCC;
      8:  return 8'h4B;
      11: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2cb_line_filter.sv
module i2cb_line_filter #(
  parameter int N_LINES     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] din,
  output logic [N_LINES-1:0] dout
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q  <= '1;
        hist_q  <= '1;
        dout[g] <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], din[g]};
        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        if (&hist_q)       dout[g] <= 1'b1;
        else if (~|hist_q) dout[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cb_proto.sv
module i2cb_proto
  import i2cb_pkg::*;
#(
  parameter logic [5:0] DEV_BASE = 6'b110000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          sda,
  input  logic          addr_sel,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output logic          stop_ev
);
  localparam logic [AW-1:0] LAST   = AW'(NUM_ALL - 1);
  localparam logic [7:0]    NALL_B = 8'(NUM_ALL);

  st_t        st;
  ph_t        ph;
  logic       scl_d, sda_d, rw, m_nack;
  logic [3:0] bitcnt;
  logic [7:0] sh;

  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_ev = scl & scl_d & sda_d & ~sda;
  assign stop_ev = scl & scl_d & ~sda_d & sda;
  wire dev_hit  = (sh[7:1] == {DEV_BASE, addr_sel});

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;  sda_d <= 1'b1;
      st <= ST_IDLE;  ph <= PH_DEV;
      bitcnt <= '0;   sh <= '0;
      rw <= 1'b0;     m_nack <= 1'b0;
      ptr <= '0;      sda_oe <= 1'b0;
      wr_en <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
      rd_fire <= 1'b0; rd_addr <= '0;
    end else begin
      scl_d   <= scl;
      sda_d   <= sda;
      wr_en   <= 1'b0;
      rd_fire <= 1'b0;
      if (start_ev) begin
        st <= ST_RX;  ph <= PH_DEV;  bitcnt <= '0;  sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE;  sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (ph)
                PH_DEV: begin
                  if (dev_hit) begin
                    rw <= sh[0];  sda_oe <= 1'b1;  st <= ST_RXACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr    <= (sh < NALL_B) ? sh[AW-1:0] : '0;
                  sda_oe <= 1'b1;  st <= ST_RXACK;
                end
                default: begin
                  wr_en   <= 1'b1;  wr_addr <= ptr;  wr_data <= sh;
                  ptr     <= next_ptr(ptr);
                  sda_oe  <= 1'b1;  st <= ST_RXACK;
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (ph == PH_DEV && rw) begin
                st <= ST_TX;  sh <= rd_data;  sda_oe <= ~rd_data[7];
                rd_fire <= 1'b1;  rd_addr <= ptr;  ptr <= next_ptr(ptr);
              end else begin
                sda_oe <= 1'b0;  st <= ST_RX;
                ph <= (ph == PH_DEV) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;  st <= ST_TXACK;
              end else begin
                sh <= {sh[6:0], 1'b0};  sda_oe <= ~sh[6];  bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) m_nack <= sda;
            else if (scl_fall) begin
              if (!m_nack) begin
                st <= ST_TX;  bitcnt <= '0;  sh <= rd_data;  sda_oe <= ~rd_data[7];
                rd_fire <= 1'b1;  rd_addr <= ptr;  ptr <= next_ptr(ptr);
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (scl && scl_d && !start_ev && !stop_ev) |=> $stable(sda_oe));
  // R3
  oe_state_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st == ST_RXACK || st == ST_TX));
  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
  // R1
  no_foreign_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RX && ph == PH_DEV && scl_fall && bitcnt == 4'd8 && !dev_hit) |=> !sda_oe);
endmodule

// File: rtl/i2cb_regfile.sv
module i2cb_regfile
  import i2cb_pkg::*;
#(
  parameter int CAL_REG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [AW-1:0]     ptr,
  input  logic              rd_fire,
  input  logic [AW-1:0]     rd_addr,
  input  logic              stop_ev,
  input  logic [6:0]        stat_a,
  input  logic [7:0]        stat_b,
  output logic [7:0]        rd_data,
  output logic [8*NUM_WR-1:0] regs_flat,
  output logic              cal_start,
  output logic              por_flag
);
  localparam logic [AW-1:0] NWR_A = AW'(NUM_WR);
  localparam logic [AW-1:0] CAL_A = AW'(CAL_REG);

  logic [7:0] regs [NUM_WR];
  logic       stat_seen;

  for (genvar g = 0; g < NUM_WR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  regs[g] <= reg_default(g);
      else if (wr_en && wr_addr == AW'(g))      regs[g] <= wr_data;
    end
    assign regs_flat[8*g +: 8] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_start <= 1'b0;  por_flag <= 1'b1;  stat_seen <= 1'b0;
    end else begin
      cal_start <= wr_en && (wr_addr == CAL_A);
      if (stop_ev) begin
        if (stat_seen) por_flag <= 1'b0;
        stat_seen <= 1'b0;
      end else if (rd_fire && rd_addr == NWR_A) begin
        stat_seen <= 1'b1;
      end
    end
  end

  always_comb begin
    if (ptr < NWR_A)        rd_data = regs[ptr];
    else if (ptr == NWR_A)  rd_data = {por_flag, stat_a};
    else                    rd_data = stat_b;
  end

  // R6
  cal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);
  // R5
  por_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !por_flag |=> !por_flag);
  // R7
  ro_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= NWR_A) |=> $stable(regs_flat));
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2cb_pkg::*;
#(
  parameter logic [5:0] DEV_BASE    = 6'b110000,
  parameter int         CAL_REG     = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        addr_sel,
  input  logic [6:0]  stat_a_in,
  input  logic [7:0]  stat_b_in,
  output logic        sda_oe,
  output logic [95:0] cfg_regs,
  output logic        cal_start,
  output logic        por_flag
);
  logic [1:0]    filt;
  logic [7:0]    rd_data, wr_data;
  logic [AW-1:0] ptr, wr_addr, rd_addr;
  logic          wr_en, rd_fire, stop_ev;

  i2cb_line_filter #(.N_LINES(2), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(filt));

  i2cb_proto #(.DEV_BASE(DEV_BASE)) u_proto (
    .clk(clk), .rst(rst), .scl(filt[1]), .sda(filt[0]), .addr_sel(addr_sel),
    .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_fire(rd_fire),
    .rd_addr(rd_addr), .stop_ev(stop_ev));

  i2cb_regfile #(.CAL_REG(CAL_REG)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr(ptr), .rd_fire(rd_fire), .rd_addr(rd_addr), .stop_ev(stop_ev),
    .stat_a(stat_a_in), .stat_b(stat_b_in), .rd_data(rd_data),
    .regs_flat(cfg_regs), .cal_start(cal_start), .por_flag(por_flag));
endmodule

// File: tb/i2c_cfg_slave_tb.sv
module i2c_cfg_slave_tb;
  localparam int Q = 10;

  logic clk = 0, rst = 1;
  logic m_scl = 1, m_sda = 1, addr_sel = 0;
  logic [6:0] stat_a = 7'h55;
  logic [7:0] stat_b = 8'hA7;
  logic sda_oe, cal_start, por_flag;
  logic [95:0] cfg_regs;
  wire  sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0, cal_cnt = 0, cal_wide = 0;
  bit done = 0;
  logic cal_prev = 0;
  logic [7:0] mdl [12];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  bit ack_all;

  always #10 clk = ~clk;

  i2c_cfg_slave u_dut (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .addr_sel(addr_sel),
    .stat_a_in(stat_a), .stat_b_in(stat_b), .sda_oe(sda_oe), .cfg_regs(cfg_regs),
    .cal_start(cal_start), .por_flag(por_flag));

  always @(posedge clk) begin
    if (cal_start) cal_cnt++;
    if (cal_start && cal_prev) cal_wide++;
    cal_prev <= cal_start;
  end

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input int i);
    case (i)
      0: return 8'h80; 1: return 8'h23; 2: return 8'h02; 3: return 8'hF6;
      4: return 8'h84; 5: return 8'h01; 6: return 8'hC0; 7: return 8'hCC;
      8: return 8'h4B; 11: return 8'h08; default: return 8'h00;
    endcase
  endfunction

  function automatic logic [95:0] mdl_vec();
    logic [95:0] v;
    for (int i = 0; i < 12; i++) v[8*i +: 8] = mdl[i];
    return v;
  endfunction

  function automatic int nxt(input int p);
    return (p == 13) ? 0 : p + 1;
  endfunction

  task automatic i2c_start();
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 0; wq(Q); m_scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    bit s1, s2;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch && i == 3) begin
        wq(2); m_scl = 1; wq(2); m_scl = 0; wq(Q - 4);
      end else wq(Q);
      m_scl = 1;
      if (glitch && i == 5 && b[i]) begin
        wq(Q - 1); m_sda = 0; wq(2); m_sda = 1; wq(Q - 1);
      end else wq(2 * Q);
      m_scl = 0; wq(Q);
    end
    m_sda = 1; wq(Q); m_scl = 1; wq(1);
    s1 = sda_line; wq(2 * Q - 2); s2 = sda_line; wq(1);
    m_scl = 0; wq(Q);
    ack = !s1 && !s2;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      m_sda = 1; wq(Q); m_scl = 1; wq(Q); b = {b[6:0], sda_line}; wq(Q); m_scl = 0; wq(Q);
    end
    m_sda = last; wq(Q); m_scl = 1; wq(2 * Q); m_scl = 0; wq(Q);
  endtask

  task automatic wr_burst(input logic [7:0] dev, input int p, input int n, input bit glitch);
    bit a;
    ack_all = 1;
    i2c_start();
    send_byte(dev, 0, a);
    ack_all &= a;
    if (a) begin
      send_byte(8'(p), 0, a); ack_all &= a;
      for (int i = 0; i < n; i++) begin
        send_byte(wbuf[i], glitch, a); ack_all &= a;
      end
    end
    i2c_stop();
  endtask

  task automatic rd_burst(input int p, input int n, input bit do_stop);
    bit a;
    ack_all = 1;
    i2c_start();
    send_byte(8'hC0, 0, a); ack_all &= a;
    send_byte(8'(p), 0, a); ack_all &= a;
    i2c_start();
    send_byte(8'hC1, 0, a); ack_all &= a;
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    if (do_stop) i2c_stop();
    else begin m_sda = 1; wq(Q); end
  endtask

  function automatic void mdl_write(input int p, input int n);
    int q = p;
    for (int i = 0; i < n; i++) begin
      if (q < 12) mdl[q] = wbuf[i];
      q = nxt(q);
    end
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 12; i++) mdl[i] = dflt(i);
    wq(5); rst = 0; wq(3);
    // R4 reset state
    chk("R4 defaults", cfg_regs, mdl_vec());
    chk("R4 sda_oe/cal idle", {sda_oe, cal_start}, 2'b00);
    chk("R5 por set at reset", por_flag, 1);

    // R1 address matching
    wr_burst(8'hC2, 0, 0, 0);
    chk("R1 foreign addr nack", ack_all, 0);
    wbuf[0] = 8'h3C;
    addr_sel = 1;
    wr_burst(8'hC2, 9, 1, 0); mdl_write(9, 1);
    chk("R1 alt addr acked", ack_all, 1);
    chk("R1 alt addr write", cfg_regs, mdl_vec());
    wbuf[0] = 8'h99;
    wr_burst(8'hC0, 9, 1, 0);
    chk("R1 C0 ignored when sel=1", {ack_all, cfg_regs}, {1'b0, mdl_vec()});
    addr_sel = 0;

    // R6 calibration strobe
    c0 = cal_cnt;
    wbuf[0] = 8'h11; wr_burst(8'hC0, 4, 1, 0); mdl_write(4, 1);
    chk("R6 one pulse on 0x04", cal_cnt - c0, 1);
    wbuf[0] = 8'h21; wbuf[1] = 8'h22; wr_burst(8'hC0, 3, 2, 0); mdl_write(3, 2);
    chk("R6 burst through 0x04", cal_cnt - c0, 2);
    wbuf[0] = 8'h5A; wr_burst(8'hC0, 5, 1, 0); mdl_write(5, 1);
    chk("R6 no pulse elsewhere", cal_cnt - c0, 2);
    chk("R6 pulse width", cal_wide, 0);

    // R7 read-only discard and wrap
    wbuf[0] = 8'h71; wbuf[1] = 8'h72; wbuf[2] = 8'h73; wbuf[3] = 8'h74;
    wr_burst(8'hC0, 11, 4, 0); mdl_write(11, 4);
    chk("R7 wrap write acked", ack_all, 1);
    chk("R7 wrap write regs", cfg_regs, mdl_vec());
    chk("R7 status unaffected", por_flag, 1);

    // R8 glitches on SCL and SDA
    wbuf[0] = 8'hE7; wr_burst(8'hC0, 2, 1, 1); mdl_write(2, 1);
    chk("R8 glitched write acked", ack_all, 1);
    chk("R8 glitched write value", cfg_regs, mdl_vec());

    // R5 power-on flag
    rd_burst(13, 1, 1);
    chk("R5 read 0x0D", rbuf[0], stat_b);
    chk("R5 no clear from 0x0D", por_flag, 1);
    rd_burst(10, 4, 0);
    chk("R3 burst 0x0A", rbuf[0], mdl[10]);
    chk("R3 burst 0x0B", rbuf[1], mdl[11]);
    chk("R5 status bit7 set", rbuf[2], {1'b1, stat_a});
    chk("R3 burst 0x0D", rbuf[3], stat_b);
    chk("R5 held before STOP", por_flag, 1);
    i2c_stop();
    chk("R5 cleared after STOP", por_flag, 0);
    rd_burst(12, 3, 1);
    chk("R5 status bit7 clear", rbuf[0], {1'b0, stat_a});
    chk("R7 read wrap to 0x00", rbuf[2], mdl[0]);
    chk("R9 read acks", ack_all, 1);

    // R2 / R3 random bursts
    for (int it = 0; it < 12; it++) begin
      int p = $urandom_range(0, 13);
      int n = $urandom_range(1, 4);
      int rp = $urandom_range(0, 10);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_burst(8'hC0, p, n, 0); mdl_write(p, n);
      chk("R2 random burst regs", {ack_all, cfg_regs}, {1'b1, mdl_vec()});
      rd_burst(rp, 2, 1);
      chk("R3 random read", {rbuf[0], rbuf[1]}, {mdl[rp], mdl[rp + 1]});
    end
    chk("R6 never wide", cal_wide, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule